// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave serial control port that gives an external host read and write access to a small internal register file of 8-bit registers. The host frames each session with an active-low chip select. Every session is two bytes long: a command byte that carries a read/write flag and a register address, then one data byte. That data byte is either written into the addressed register or read back from it.

The port works out how to talk to the host at the start of each session. It looks at the serial clock level at the moment chip select falls. If the clock is idling high, the session uses a single bidirectional data pin and both bytes travel least significant bit first. If the clock is idling low, the session follows SPI mode 0 (CPOL=0, CPHA=0). In that mode bytes travel most significant bit first, data arrives on the second pin and replies leave on the first pin. All pins are sampled by a fast system clock, and edges of the serial clock and chip select are detected internally. The register file sits outside the block and is reached through an address, a one-cycle write strobe and a one-cycle read strobe. Read data must be valid combinationally in the cycle of the read strobe.

Top module: `dual_mode_serial_port`

## Requirements
- R1: On each falling edge of chip select the serial clock level is captured. A high level selects bidirectional LSB-first mode, a low level selects SPI mode 0 MSB-first, and the choice holds for the whole session.
- R2: In bidirectional mode, incoming bits are taken from `dat1_i` and `dat2_i` is ignored. The first bit received is bit 0 of each byte, and read data leaves bit 0 first.
- R3: In SPI mode, incoming bits are taken from `dat2_i` and `dat1_i` is ignored. The first bit received is bit 7 of each byte, and read data leaves bit 7 first.
- R4: In the assembled command byte, bit 0 is the read/write flag (1 = read) and bits 3:1 are the register address. Bits 7:4 have no effect.
- R5: A write session gives exactly one `reg_wr_o` pulse, one system clock after the 16th rising serial clock edge, carrying the address and the assembled data byte.
- R6: A read session gives one `reg_rd_o` pulse, one system clock after the 8th rising edge, with the address valid. The byte read then appears on `dat1_o` one bit per falling serial clock edge.
- R7: `dat1_o` changes only one system clock after a detected falling serial clock edge.
- R8: `dat1_oe` is low while chip select is high and through the command phase of every session and all of a write session. It rises with the first data-phase falling edge of a read and stays high until chip select rises.
- R9: If chip select rises before 16 bits have been received, no register write occurs.
- R10: Serial clock edges after the 16th bit of a session are ignored. A new command byte is accepted only after chip select goes high and then low again.
- R11: After reset, `dat1_oe`, `reg_wr_o` and `reg_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| dat1_i | input | 1 | Data pin 1 input (receive pin in bidirectional mode) |
| dat2_i | input | 1 | Data pin 2 input (receive pin in SPI mode) |
| dat1_o | output | 1 | Data pin 1 output value |
| dat1_oe | output | 1 | Output enable for data pin 1 (0 = high impedance) |
| reg_addr_o | output | ADDR_W | Register address from the command byte |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | DATA_W | Register read data, valid in the `reg_rd_o` cycle |

## Verification
The assertions assume that chip select and the serial clock are already synchronous to `clk`. They also assume that every serial clock level is held for several system clocks, and that chip select never moves in the same cycle as a serial clock edge. The bench drives all pins on the falling system clock edge and holds each serial clock phase for four cycles. It changes chip select only while the serial clock rests at its idle level. To show that the unused pin is ignored, the bench drives the inverse of the real data bit onto that pin. It also drives junk on the receive pin during reads.

// File: rtl/dual_mode_serial_port.sv
module dual_mode_serial_port #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              dat1_i,
  input  logic              dat2_i,
  output logic              dat1_o,
  output logic              dat1_oe,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int unsigned CNT_W = $clog2(2*DATA_W+1);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(2*DATA_W);

  logic              cs_q, sclk_q, active, lsb_mode, rw_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh, tx;
  logic [IDX_W-1:0]  idx;

  wire cs_fall   = cs_q & ~cs_n_i;
  wire sclk_rise = sclk_i & ~sclk_q;
  wire sclk_fall = ~sclk_i & sclk_q;
  wire bit_in    = lsb_mode ? dat1_i : dat2_i;
  wire [DATA_W-1:0] sh_nxt = lsb_mode ? {bit_in, sh[DATA_W-1:1]}
                                      : {sh[DATA_W-2:0], bit_in};
  wire take  = active & sclk_rise & (cnt < FULL);
  wire drive = active & sclk_fall & rw_q & (cnt >= HALF) & (cnt < FULL);

  assign idx = cnt[IDX_W-1:0];
  wire tx_bit = lsb_mode ? tx[idx] : tx[~idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      sclk_q      <= 1'b0;
      active      <= 1'b0;
      lsb_mode    <= 1'b0;
      rw_q        <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      dat1_o      <= 1'b0;
      dat1_oe     <= 1'b0;
      reg_addr_o  <= '0;
      reg_wr_o    <= 1'b0;
      reg_wdata_o <= '0;
      reg_rd_o    <= 1'b0;
    end else begin
      cs_q     <= cs_n_i;
      sclk_q   <= sclk_i;
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      if (reg_rd_o) tx <= reg_rdata_i;
      if (cs_n_i) begin
        active  <= 1'b0;
        dat1_oe <= 1'b0;
      end else if (cs_fall) begin
        active   <= 1'b1;
        lsb_mode <= sclk_i;
        cnt      <= '0;
      end else begin
        if (take) begin
          sh  <= sh_nxt;
          cnt <= cnt + CNT_W'(1);
          if (cnt == HALF - CNT_W'(1)) begin
            rw_q       <= sh_nxt[0];
            reg_addr_o <= sh_nxt[ADDR_W:1];
            reg_rd_o   <= sh_nxt[0];
          end
          if (cnt == FULL - CNT_W'(1) && !rw_q) begin
            reg_wr_o    <= 1'b1;
            reg_wdata_o <= sh_nxt;
          end
        end
        if (drive) begin
          dat1_oe <= 1'b1;
          dat1_o  <= tx_bit;
        end
      end
    end
  end

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cs_n_i) |=> $stable(lsb_mode));
  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);
  p_rd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);
  p_dout_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(dat1_o));
  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> !dat1_oe);
  p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat1_oe |-> rw_q);
  p_wr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (cnt == FULL));
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
endmodule

// File: tb/dual_mode_serial_port_tb_top.sv
`timescale 1ns/1ps
module dual_mode_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, d1 = 1'b0, d2 = 1'b0;
  logic dout, doe, rwr, rrd;
  logic [2:0] raddr;
  logic [7:0] rwdata, rrdata;
  logic [7:0] rf [8];

  int errors = 0, checks = 0, wr_seen = 0;
  bit mon_on = 0;

  logic m_cs = 1'b1, m_sc = 1'b0, m_active = 1'b0, m_lsb = 1'b0, m_rw = 1'b0;
  int m_cnt = 0;
  logic [15:0] m_rx;
  logic [2:0] m_addr;
  logic [7:0] m_tx;
  logic [7:0] mem [8];
  logic exp_oe = 0, exp_dout = 0, exp_wr = 0, exp_rd = 0;
  logic [2:0] exp_addr = '0;
  logic [7:0] exp_wdata = '0;

  always #2 clk = ~clk;

  dual_mode_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .dat1_i(d1), .dat2_i(d2), .dat1_o(dout), .dat1_oe(doe),
    .reg_addr_o(raddr), .reg_wr_o(rwr), .reg_wdata_o(rwdata),
    .reg_rd_o(rrd), .reg_rdata_i(rrdata)
  );

  assign rrdata = rf[raddr];
  always @(posedge clk) if (rwr) rf[raddr] <= rwdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rwr) wr_seen++;
    if (mon_on) begin
      chk(doe == exp_oe, "R8", "output enable", doe, exp_oe);
      chk(rwr == exp_wr, "R5", "write strobe", rwr, exp_wr);
      chk(rrd == exp_rd, "R6", "read strobe", rrd, exp_rd);
      if (exp_wr) begin
        chk(raddr == exp_addr, "R4", "write address", raddr, exp_addr);
        chk(rwdata == exp_wdata, "R5", "write data", rwdata, exp_wdata);
      end
      if (exp_rd) chk(raddr == exp_addr, "R4", "read address", raddr, exp_addr);
      if (exp_oe) chk(dout == exp_dout, "R7", "output bit", dout, exp_dout);
    end
  end

  task automatic step(input logic cs, input logic sc, input logic a, input logic b);
    logic [7:0] byt;
    @(negedge clk);
    exp_wr = 0;
    exp_rd = 0;
    cs_n = cs; sclk = sc; d1 = a; d2 = b;
    if (cs) begin
      m_active = 0;
      exp_oe = 0;
    end else if (m_cs) begin
      m_active = 1;
      m_lsb = sc;
      m_cnt = 0;
    end else if (m_active) begin
      if (sc && !m_sc && m_cnt < 16) begin
        m_rx[m_cnt] = m_lsb ? a : b;
        m_cnt++;
        if (m_cnt == 8) begin
          for (int k = 0; k < 8; k++) byt[k] = m_lsb ? m_rx[k] : m_rx[7-k];
          m_rw = byt[0];
          m_addr = byt[3:1];
          if (m_rw) begin
            exp_rd = 1;
            exp_addr = m_addr;
            m_tx = mem[m_addr];
          end
        end
        if (m_cnt == 16 && !m_rw) begin
          for (int k = 0; k < 8; k++) byt[k] = m_lsb ? m_rx[8+k] : m_rx[15-k];
          exp_wr = 1;
          exp_addr = m_addr;
          exp_wdata = byt;
          mem[m_addr] = byt;
        end
      end
      if (!sc && m_sc && m_rw && m_cnt >= 8 && m_cnt < 16) begin
        exp_oe = 1;
        exp_dout = m_lsb ? m_tx[m_cnt-8] : m_tx[15-m_cnt];
      end
    end
    m_cs = cs;
    m_sc = sc;
  endtask

  task automatic xfer(input bit lsb, input bit rw, input logic [2:0] a,
                      input logic [7:0] d, input logic [3:0] junk,
                      input int nbits, input int extra, output logic [7:0] got);
    logic [7:0] cmd, src;
    logic b, p1, p2;
    cmd = {junk, a, rw};
    got = '0;
    repeat (3) step(1, lsb, 0, 0);
    step(0, lsb, 0, 0);
    for (int i = 0; i < nbits + extra; i++) begin
      src = (i < 8) ? cmd : (i < 16 ? (rw ? 8'h5A : d) : 8'hC3);
      b = lsb ? src[i%8] : src[7-(i%8)];
      p1 = lsb ? b : ~b;
      p2 = lsb ? ~b : b;
      repeat (4) step(0, 0, p1, p2);
      if (i >= 8 && i < 16) begin
        if (lsb) got[i-8] = dout;
        else got[15-i] = dout;
      end
      repeat (4) step(0, 1, p1, p2);
    end
    if (!lsb) repeat (2) step(0, 0, 0, 0);
    repeat (2) step(1, lsb, 0, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int w0;
    for (int k = 0; k < 8; k++) begin rf[k] = '0; mem[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(doe == 0, "R11", "reset oe", doe, 0);
    chk(rwr == 0, "R11", "reset write", rwr, 0);
    chk(rrd == 0, "R11", "reset read", rrd, 0);
    mon_on = 1;

    w0 = wr_seen;
    xfer(1, 0, 3'd3, 8'hA5, 4'hF, 16, 0, got);
    chk(wr_seen - w0 == 1, "R2", "bidir write count", wr_seen - w0, 1);
    chk(rf[3] == 8'hA5, "R4", "upper cmd bits ignored", rf[3], 8'hA5);
    xfer(1, 1, 3'd3, 8'h00, 4'h0, 16, 0, got);
    chk(got == 8'hA5, "R2", "bidir read LSB first", got, 8'hA5);

    xfer(0, 0, 3'd5, 8'h3C, 4'hA, 16, 0, got);
    chk(rf[5] == 8'h3C, "R3", "SPI write MSB first", rf[5], 8'h3C);
    xfer(0, 1, 3'd5, 8'h00, 4'h0, 16, 0, got);
    chk(got == 8'h3C, "R3", "SPI read MSB first", got, 8'h3C);
    xfer(0, 1, 3'd3, 8'h00, 4'h0, 16, 0, got);
    chk(got == 8'hA5, "R1", "mode per session", got, 8'hA5);

    w0 = wr_seen;
    xfer(0, 0, 3'd5, 8'hFF, 4'h0, 12, 0, got);
    xfer(1, 0, 3'd5, 8'hFF, 4'h0, 4, 0, got);
    chk(wr_seen == w0, "R9", "aborted writes", wr_seen - w0, 0);
    xfer(1, 1, 3'd5, 8'h00, 4'h0, 16, 0, got);
    chk(got == 8'h3C, "R9", "register kept", got, 8'h3C);

    w0 = wr_seen;
    xfer(1, 0, 3'd0, 8'h81, 4'h0, 16, 8, got);
    chk(wr_seen - w0 == 1, "R10", "extra clocks ignored", wr_seen - w0, 1);
    xfer(0, 1, 3'd0, 8'h00, 4'h0, 16, 8, got);
    chk(got == 8'h81, "R10", "read with extra clocks", got, 8'h81);
    chk(rf[0] == 8'h81, "R10", "no stray write", rf[0], 8'h81);

    for (int a = 0; a < 8; a++) begin
      xfer(a % 2, 0, 3'(a), 8'(a * 37 + 11), 4'(a), 16, 0, got);
    end
    for (int a = 0; a < 8; a++) begin
      xfer((a + 1) % 2, 1, 3'(a), 8'h00, 4'(7 - a), 16, 0, got);
      chk(got == 8'(a * 37 + 11), "R6", "sweep readback", got, 8'(a * 37 + 11));
    end

    repeat (4) @(negedge clk);
    chk(doe == 0, "R8", "idle oe", doe, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule